// File: doc/BRIEF.md
# Asynchronous Memory Read Strobe Generator

This block produces the control waveforms for a read from an external asynchronous static memory, timed entirely off one system clock. Once a request is accepted it drives a chip-select and a read strobe, both active low. Each strobe has its own setup count and pulse count. A total access length applies to both. All counts are in clock cycles. The address and the byte enables are held on the pins for the whole access.

A single mode bit picks the strobe whose deasserting edge marks the capture of the external data bus. The block never compares the two waveforms to find out which one releases first. The captured word goes back to the requester together with a one-cycle acknowledge. A pulse count programmed as zero is illegal. Such a count is forced to one cycle and raises a sticky error flag.

Top module: `sram_read_seq`

## Requirements
- R1: While reset is asserted and right after it, memCsN and memRdN are 1, memBeN is all ones, ackValid is 0, reqReady is 1 and cfgErr is 0.
- R2: Cycle k of an access is the clock period that follows the k-th edge after the accepting edge, counting from 0. memCsN is 0 exactly in the cycles csSetup <= k < csSetup + csPulse, and the read-strobe fields have no effect on it. A setup of 0 asserts the strobe in cycle 0. With zero hold it stays low up to the last cycle.
- R3: memRdN is 0 exactly in the cycles rdSetup <= k < rdSetup + rdPulse, and the chip-select fields have no effect on it.
- R4: A pulse field of 0 behaves as a pulse of 1 cycle.
- R5: cfgErr becomes 1 when a request is accepted with cfgCsPulse or cfgRdPulse equal to 0. It then stays 1 until reset.
- R6: The access lasts L = max(cfgCycle, csSetup+csPulse, rdSetup+rdPulse) cycles. reqReady is 0 in cycles 0..L-1 and 1 from cycle L on. A request is accepted only on an edge where reqReady is 1.
- R7: With cfgRdMode = 1 the data bus is sampled on the edge that raises memRdN. With cfgRdMode = 0 it is sampled on the edge that raises memCsN. ackValid is 1 in the cycle that follows that edge, and ackData carries the sampled word.
- R8: ackValid is a single-cycle pulse, and there is exactly one per access.
- R9: memAddr equals the accepted address during cycles 0..L-1. memBeN equals the bitwise inverse of the accepted byte enables during those cycles, and it is all ones when no access is running.
- R10: All timing fields and the mode bit are sampled on the accepting edge. Changes made to them later do not affect the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Read request |
| reqAddr | input | ADDR_W | Read address |
| reqBe | input | BE_W | Byte enables, active high |
| reqReady | output | 1 | Idle; a request is taken on this edge |
| ackValid | output | 1 | Read data valid pulse |
| ackData | output | DATA_W | Captured read data |
| cfgCsSetup | input | CNT_W | Chip-select setup cycles |
| cfgCsPulse | input | CNT_W | Chip-select pulse cycles |
| cfgRdSetup | input | CNT_W | Read-strobe setup cycles |
| cfgRdPulse | input | CNT_W | Read-strobe pulse cycles |
| cfgCycle | input | CNT_W+1 | Total access cycles |
| cfgRdMode | input | 1 | 1: read strobe marks capture, 0: chip-select does |
| cfgErr | output | 1 | Sticky zero-pulse error |
| memAddr | output | ADDR_W | External address |
| memBeN | output | BE_W | External byte enables, active low |
| memCsN | output | 1 | External chip-select, active low |
| memRdN | output | 1 | External read strobe, active low |
| memData | input | DATA_W | External data bus |

## Verification
The assertions assume that the requester watches reqReady and never expects a request to be taken while an access is running. They also assume that the data bus has settled before the capture edge chosen by the mode bit. The bench drives every input half a period away from the active edge. It changes memData only at falling edges, so the word present at the capture edge is known. It keeps reqValid high during the whole access and scrambles every timing field right after acceptance. A request that the block wrongly takes or re-samples therefore shows up as a wrong waveform on the pins.

// File: rtl/srs_pkg.sv
package srs_pkg;
  // Per-cycle commands from the sequencer to the pin datapath
  typedef struct packed {
    logic load;     // request accepted on this edge
    logic active;   // access runs in the next cycle
    logic csOn;     // chip-select asserted in the next cycle
    logic rdOn;     // read strobe asserted in the next cycle
    logic capture;  // sample the data bus on this edge
  } srsStrobes_t;
endpackage

// File: rtl/srs_ctrl.sv
module srs_ctrl #(
  parameter int CNT_W = 4,
  localparam int SUM_W = CNT_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [CNT_W-1:0]     cfgCsSetup,
  input  logic [CNT_W-1:0]     cfgCsPulse,
  input  logic [CNT_W-1:0]     cfgRdSetup,
  input  logic [CNT_W-1:0]     cfgRdPulse,
  input  logic [SUM_W-1:0]     cfgCycle,
  input  logic                 cfgRdMode,
  output logic                 reqReady,
  output logic                 cfgErr,
  output srs_pkg::srsStrobes_t strobes
);
  logic             busy;
  logic [SUM_W-1:0] cnt, lastQ, capQ, csSetQ, csEndQ, rdSetQ, rdEndQ;
  logic             accept, nBusy;
  logic [CNT_W-1:0] csPl, rdPl;
  logic [SUM_W-1:0] csEndIn, rdEndIn, lenIn, capIn, nCnt;
  logic [SUM_W-1:0] nCsSet, nCsEnd, nRdSet, nRdEnd;

  always_comb begin
    accept  = reqValid && !busy;
    // a zero pulse is clamped to a single cycle
    csPl    = (cfgCsPulse == '0) ? CNT_W'(1) : cfgCsPulse;
    rdPl    = (cfgRdPulse == '0) ? CNT_W'(1) : cfgRdPulse;
    csEndIn = SUM_W'(cfgCsSetup) + SUM_W'(csPl);
    rdEndIn = SUM_W'(cfgRdSetup) + SUM_W'(rdPl);
    // the access is stretched so that both pulses fit
    lenIn   = cfgCycle;
    if (csEndIn > lenIn) lenIn = csEndIn;
    if (rdEndIn > lenIn) lenIn = rdEndIn;
    capIn   = (cfgRdMode ? rdEndIn : csEndIn) - SUM_W'(1);

    nBusy  = accept || (busy && (cnt != lastQ));
    nCnt   = accept ? '0 : cnt + SUM_W'(1);
    nCsSet = accept ? SUM_W'(cfgCsSetup) : csSetQ;
    nCsEnd = accept ? csEndIn : csEndQ;
    nRdSet = accept ? SUM_W'(cfgRdSetup) : rdSetQ;
    nRdEnd = accept ? rdEndIn : rdEndQ;

    strobes.load    = accept;
    strobes.active  = nBusy;
    strobes.csOn    = nBusy && (nCnt >= nCsSet) && (nCnt < nCsEnd);
    strobes.rdOn    = nBusy && (nCnt >= nRdSet) && (nCnt < nRdEnd);
    strobes.capture = busy && (cnt == capQ);
    reqReady        = !busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cnt    <= '0;
      lastQ  <= '0;
      capQ   <= '0;
      csSetQ <= '0;
      csEndQ <= '0;
      rdSetQ <= '0;
      rdEndQ <= '0;
      cfgErr <= 1'b0;
    end else if (accept) begin
      busy   <= 1'b1;
      cnt    <= '0;
      lastQ  <= lenIn - SUM_W'(1);
      capQ   <= capIn;
      csSetQ <= SUM_W'(cfgCsSetup);
      csEndQ <= csEndIn;
      rdSetQ <= SUM_W'(cfgRdSetup);
      rdEndQ <= rdEndIn;
      if ((cfgCsPulse == '0) || (cfgRdPulse == '0)) cfgErr <= 1'b1;
    end else if (busy) begin
      if (cnt == lastQ) busy <= 1'b0;
      else              cnt  <= cnt + SUM_W'(1);
    end
  end
endmodule

// File: rtl/srs_dpath.sv
module srs_dpath #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int BE_W   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  srs_pkg::srsStrobes_t strobes,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [BE_W-1:0]      reqBe,
  input  logic [DATA_W-1:0]    memData,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [BE_W-1:0]      memBeN,
  output logic                 memCsN,
  output logic                 memRdN,
  output logic                 ackValid,
  output logic [DATA_W-1:0]    ackData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memBeN   <= '1;
      memCsN   <= 1'b1;
      memRdN   <= 1'b1;
      ackValid <= 1'b0;
      ackData  <= '0;
    end else begin
      if (strobes.load) begin
        memAddr <= reqAddr;
        memBeN  <= ~reqBe;
      end else if (!strobes.active) begin
        memBeN  <= '1;
      end
      memCsN   <= ~strobes.csOn;
      memRdN   <= ~strobes.rdOn;
      ackValid <= strobes.capture;
      if (strobes.capture) ackData <= memData;
    end
  end
endmodule

// File: rtl/sram_read_seq.sv
module sram_read_seq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int BE_W   = 2,
  parameter int CNT_W  = 4,
  localparam int SUM_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BE_W-1:0]   reqBe,
  output logic              reqReady,
  output logic              ackValid,
  output logic [DATA_W-1:0] ackData,
  input  logic [CNT_W-1:0]  cfgCsSetup,
  input  logic [CNT_W-1:0]  cfgCsPulse,
  input  logic [CNT_W-1:0]  cfgRdSetup,
  input  logic [CNT_W-1:0]  cfgRdPulse,
  input  logic [SUM_W-1:0]  cfgCycle,
  input  logic              cfgRdMode,
  output logic              cfgErr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BE_W-1:0]   memBeN,
  output logic              memCsN,
  output logic              memRdN,
  input  logic [DATA_W-1:0] memData
);
  srs_pkg::srsStrobes_t strobes;

  srs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .cfgCsSetup(cfgCsSetup), .cfgCsPulse(cfgCsPulse),
    .cfgRdSetup(cfgRdSetup), .cfgRdPulse(cfgRdPulse),
    .cfgCycle(cfgCycle), .cfgRdMode(cfgRdMode),
    .reqReady(reqReady), .cfgErr(cfgErr), .strobes(strobes)
  );

  srs_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqAddr(reqAddr), .reqBe(reqBe), .memData(memData),
    .memAddr(memAddr), .memBeN(memBeN), .memCsN(memCsN),
    .memRdN(memRdN), .ackValid(ackValid), .ackData(ackData)
  );
endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int ADDR_W = 8,
  parameter int BE_W   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              ackValid,
  input logic              cfgErr,
  input logic [ADDR_W-1:0] memAddr,
  input logic [BE_W-1:0]   memBeN,
  input logic              memCsN,
  input logic              memRdN
);
  p_cs_in_access_r2: assert property (@(posedge clk) disable iff (!rstN)
    !memCsN |-> !reqReady);
  p_rd_in_access_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memRdN |-> !reqReady);
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);
  p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  p_ack_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> !ackValid);
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && !$past(reqReady)) |-> $stable(memAddr));
  p_be_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memBeN == '1));
endmodule

bind sram_read_seq srs_checker #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_srs_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .ackValid(ackValid), .cfgErr(cfgErr), .memAddr(memAddr),
  .memBeN(memBeN), .memCsN(memCsN), .memRdN(memRdN)
);

// File: tb/sram_read_seq_bench.sv
module sram_read_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int BE_W   = 2;
  localparam int CNT_W  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [BE_W-1:0] reqBe = '0;
  logic reqReady, ackValid, cfgErr, memCsN, memRdN;
  logic [DATA_W-1:0] ackData;
  logic [CNT_W-1:0] cfgCsSetup = '0, cfgCsPulse = '0, cfgRdSetup = '0, cfgRdPulse = '0;
  logic [CNT_W:0] cfgCycle = '0;
  logic cfgRdMode = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic [BE_W-1:0] memBeN;
  logic [DATA_W-1:0] memData = '0;

  int total = 0;
  int bad = 0;
  bit errExp = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_read_seq u_sram_read_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqBe(reqBe),
    .reqReady(reqReady), .ackValid(ackValid), .ackData(ackData),
    .cfgCsSetup(cfgCsSetup), .cfgCsPulse(cfgCsPulse), .cfgRdSetup(cfgRdSetup),
    .cfgRdPulse(cfgRdPulse), .cfgCycle(cfgCycle), .cfgRdMode(cfgRdMode),
    .cfgErr(cfgErr), .memAddr(memAddr), .memBeN(memBeN), .memCsN(memCsN),
    .memRdN(memRdN), .memData(memData)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] dataFor(input int idx, input int k);
    return DATA_W'(16'h5A00 ^ (idx << 5) ^ k);
  endfunction

  task automatic checkIdle(input string req);
    chk({req, " memCsN"}, int'(memCsN), 1);
    chk({req, " memRdN"}, int'(memRdN), 1);
    chk({req, " memBeN"}, int'(memBeN), (1 << BE_W) - 1);
    chk({req, " ackValid"}, int'(ackValid), 0);
    chk({req, " reqReady"}, int'(reqReady), 1);
    chk({req, " cfgErr"}, int'(cfgErr), 0);
  endtask

  // Called at a falling edge while idle; returns at a falling edge while idle.
  task automatic runAccess(input int cs, input int csp, input int rs, input int rsp,
                           input int cyc, input int mode, input int idx);
    int csPl, rdPl, csEnd, rdEnd, len, capEnd, acks;
    logic [ADDR_W-1:0] addr;
    logic [BE_W-1:0] be;
    csPl = (csp == 0) ? 1 : csp;   // R4 clamp
    rdPl = (rsp == 0) ? 1 : rsp;
    csEnd = cs + csPl;
    rdEnd = rs + rdPl;
    len = cyc;
    if (csEnd > len) len = csEnd;
    if (rdEnd > len) len = rdEnd;
    capEnd = (mode != 0) ? rdEnd : csEnd;
    if (csp == 0 || rsp == 0) errExp = 1'b1;
    addr = ADDR_W'(idx * 37 + 11);
    be = BE_W'(idx + 1);
    chk("R6 ready before request", int'(reqReady), 1);
    cfgCsSetup = CNT_W'(cs);
    cfgCsPulse = CNT_W'(csp);
    cfgRdSetup = CNT_W'(rs);
    cfgRdPulse = CNT_W'(rsp);
    cfgCycle = (CNT_W+1)'(cyc);
    cfgRdMode = mode[0];
    reqAddr = addr;
    reqBe = be;
    reqValid = 1'b1;
    @(negedge clk);
    // R10: scramble every field after the accepting edge
    cfgCsSetup = ~CNT_W'(cs);
    cfgCsPulse = CNT_W'(0);
    cfgRdSetup = ~CNT_W'(rs);
    cfgRdPulse = CNT_W'(0);
    cfgCycle = '1;
    cfgRdMode = ~mode[0];
    reqAddr = ~addr;
    reqBe = ~be;
    acks = 0;
    for (int k = 0; k < len + 2; k++) begin
      reqValid = (k < len);    // R6: request held while busy must be ignored
      memData = dataFor(idx, k);
      chk("R2,R4,R10 memCsN", int'(memCsN), (k >= cs && k < csEnd) ? 0 : 1);
      chk("R3,R4,R10 memRdN", int'(memRdN), (k >= rs && k < rdEnd) ? 0 : 1);
      chk("R6 reqReady", int'(reqReady), (k >= len) ? 1 : 0);
      chk("R9 memBeN", int'(memBeN), (k < len) ? int'(BE_W'(~be)) : (1 << BE_W) - 1);
      if (k < len) chk("R9 memAddr", int'(memAddr), int'(addr));
      chk("R7 ackValid", int'(ackValid), (k == capEnd) ? 1 : 0);
      if (k == capEnd) chk("R7 ackData", int'(ackData), int'(dataFor(idx, capEnd - 1)));
      if (ackValid) acks++;
      @(negedge clk);
    end
    reqValid = 1'b0;
    chk("R8 one ack per access", acks, 1);
    chk("R5 cfgErr", int'(cfgErr), int'(errExp));
  endtask

  initial begin
    int idx;
    int maxEnd;
    int cyc;
    idx = 0;
    repeat (3) @(negedge clk);
    checkIdle("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 after reset");
    for (int mode = 0; mode < 2; mode++)
      for (int cs = 0; cs < 3; cs++)
        for (int csp = 0; csp < 4; csp++)
          for (int rs = 0; rs < 3; rs++)
            for (int rsp = 0; rsp < 4; rsp++)
              for (int cv = 0; cv < 3; cv++) begin
                maxEnd = cs + ((csp == 0) ? 1 : csp);
                if (rs + ((rsp == 0) ? 1 : rsp) > maxEnd) maxEnd = rs + ((rsp == 0) ? 1 : rsp);
                cyc = (cv == 0) ? 0 : (cv == 1) ? maxEnd : maxEnd + 2;
                runAccess(cs, (csp + 1) % 4, rs, (rsp + 1) % 4, cyc, mode, idx);
                idx++;
              end
    chk("R5 sticky set", int'(cfgErr), 1);
    rstN = 1'b0;
    @(negedge clk);
    chk("R5 cleared by reset", int'(cfgErr), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 second reset");
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 150000; t++) begin
      if (done) break;
      @(posedge clk);
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule